// File: doc/BRIEF.md
# Two-Port Synchronous Burst RAM

This block is a true two-port memory of 18-bit words. Each side, left and right, runs on its own clock and sees the same storage. On every rising edge of its clock a side captures its address, write data and every control line, so nothing that happens between edges affects it. The captured address is held in a small burst counter. That counter can take the external address, step to the next word, or return to zero. A long transfer therefore needs only one address, followed by count pulses.

Writes are masked per 9-bit lane. A read returns the addressed word with any lane that was not enabled forced to zero. A per-side mode pin chooses how read data is timed. In flow-through mode the data comes straight from storage after the captured address. In pipelined mode it passes through one more register and arrives one cycle later. If one side reads a word while the other side writes it, the read returns either the old or the new contents. If both sides write the same word in the same cycle, the result is undefined and callers must avoid it.

Top module: `dpram_burst2`

## Requirements
- R1: Address, write data and all control inputs of a side take effect only as sampled at that side's rising clock edge. Changes between edges do not alter the read data of the current cycle.
- R2: A side writes only in a cycle captured with `cs0_n` = 0, `cs1` = 1 and `rw_n` = 0. With either chip select inactive the storage is unchanged.
- R3: `lane_n[0]` (active low) enables bits 8:0 and `lane_n[1]` enables bits 17:9. A write changes only the enabled lanes, and a word just written reads back through the same side.
- R4: A read cycle (both chip selects active, `rw_n` = 1, `outen_n` = 0) returns the stored word with disabled lanes as zero. Write cycles, deselected cycles and cycles with `outen_n` = 1 drive zero on `rdata`.
- R5: The burst counter obeys `clr_n` first (to 0), then `load_n` (take `addr`), then `adv_n` (add one). With all three high it holds its value. All three are active low.
- R6: Advancing from the last address (2^ADDR_W − 1) wraps the counter to 0.
- R7: With `pipe` = 0, data for the access captured at edge k is valid on `rdata` after edge k, until edge k+1.
- R8: With `pipe` = 1, the same data appears one edge later, after edge k+1.
- R9: The two sides run from unrelated clocks, and data written by either side is read back unchanged by the other.
- R10: A read of a word that the other side is writing at the same time returns either the old word or the new word.
- R11: An active-low side reset clears that side's counter to 0 and its `rdata` to 0. It leaves the storage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Left side clock |
| l_rst_n | input | 1 | Left side asynchronous reset, active low |
| l_addr | input | ADDR_W | Left external address for counter load |
| l_wdata | input | 18 | Left write data |
| l_rw_n | input | 1 | Left direction: 1 read, 0 write |
| l_cs0_n | input | 1 | Left chip select, active low |
| l_cs1 | input | 1 | Left chip select, active high |
| l_lane_n | input | 2 | Left lane enables, active low, bit 0 = bits 8:0 |
| l_outen_n | input | 1 | Left read output enable, active low |
| l_load_n | input | 1 | Left counter load, active low |
| l_adv_n | input | 1 | Left counter advance, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_pipe | input | 1 | Left read mode: 1 pipelined, 0 flow-through |
| l_rdata | output | 18 | Left read data |
| r_clk | input | 1 | Right side clock |
| r_rst_n | input | 1 | Right side asynchronous reset, active low |
| r_addr | input | ADDR_W | Right external address for counter load |
| r_wdata | input | 18 | Right write data |
| r_rw_n | input | 1 | Right direction: 1 read, 0 write |
| r_cs0_n | input | 1 | Right chip select, active low |
| r_cs1 | input | 1 | Right chip select, active high |
| r_lane_n | input | 2 | Right lane enables, active low, bit 0 = bits 8:0 |
| r_outen_n | input | 1 | Right read output enable, active low |
| r_load_n | input | 1 | Right counter load, active low |
| r_adv_n | input | 1 | Right counter advance, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_pipe | input | 1 | Right read mode: 1 pipelined, 0 flow-through |
| r_rdata | output | 18 | Right read data |

## Verification
The hardest case to reach from the ports is a read on one side that lands on a word while the other side, on an unrelated clock, is writing it. Which of the two values comes back depends on how the edges fall. The bench forks the two sides. The left side writes a known new value into a word whose old value is also known. At the same time the right side reads that word several times in a row on its slower clock, and each read is accepted if it returns either value. Lane ownership is also mixed on purpose: partial-lane writes from one side are followed by whole-word reads from the other side. This shows that each lane resolves its latest writer separately.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  // Expand per-lane enables into a bit mask over the word.
  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] en);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{en[i]}};
    return m;
  endfunction

  // Zero every lane whose enable is low.
  function automatic logic [WORD_W-1:0] lane_gate(input logic [WORD_W-1:0] w,
                                                  input logic [LANES-1:0] en);
    return w & lane_mask(en);
  endfunction
endpackage

// File: rtl/dpram_port_front.sv
`timescale 1ns/1ps
module dpram_port_front
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [WORD_W-1:0] wdata_in,
  input  logic              rw_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic [LANES-1:0]  lane_n,
  input  logic              outen_n,
  input  logic              load_n,
  input  logic              adv_n,
  input  logic              clr_n,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] wdata_q,
  output logic              wr_q,
  output logic              rd_q,
  output logic              outen_q,
  output logic [LANES-1:0]  lane_q
);
  // Counter step: clear beats load, load beats advance; width wraps.
  function automatic logic [ADDR_W-1:0] cnt_step(input logic [ADDR_W-1:0] cur,
                                                 input logic [ADDR_W-1:0] ext,
                                                 input logic clr, input logic ld,
                                                 input logic adv);
    if (clr) return '0;
    if (ld)  return ext;
    if (adv) return cur + 1'b1;
    return cur;
  endfunction

  // Named decode events
  logic sel_ev, wr_ev, rd_ev;
  logic [ADDR_W-1:0] cnt_nxt;

  assign sel_ev  = !cs0_n && cs1;
  assign wr_ev   = sel_ev && !rw_n;
  assign rd_ev   = sel_ev && rw_n;
  assign cnt_nxt = cnt_step(addr_q, addr_in, !clr_n, !load_n, !adv_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      outen_q <= 1'b0;
      lane_q  <= '0;
    end else begin
      addr_q  <= cnt_nxt;
      wdata_q <= wdata_in;
      wr_q    <= wr_ev;
      rd_q    <= rd_ev;
      outen_q <= !outen_n;
      lane_q  <= ~lane_n;
    end
  end

  // R5
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (addr_q == '0));
  // R5
  load_over_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (addr_q == $past(addr_in)));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && adv_n) |=> $stable(addr_q));
  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !adv_n && addr_q == '1) |=> (addr_q == '0));
endmodule

// File: rtl/dpram_lane_store.sv
`timescale 1ns/1ps
module dpram_lane_store #(
  parameter int ADDR_W = 11,
  parameter int W      = 9
) (
  input  logic              a_clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [W-1:0]      a_wd,
  output logic [W-1:0]      a_rd,
  input  logic              b_clk,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [W-1:0]      b_wd,
  output logic [W-1:0]      b_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  // One bank per side, each written by one clock only. A pair of
  // ownership bits per word says which bank holds the latest write:
  // equal bits mean side A, unequal bits mean side B.
  logic [W-1:0] bank_a [DEPTH];
  logic [W-1:0] bank_b [DEPTH];
  logic         own_a  [DEPTH];
  logic         own_b  [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      own_a[i] = 1'b0;
      own_b[i] = 1'b0;
    end
  end

  always_ff @(posedge a_clk) begin
    if (a_we) begin
      bank_a[a_addr] <= a_wd;
      own_a[a_addr]  <= own_b[a_addr];
    end
  end

  always_ff @(posedge b_clk) begin
    if (b_we) begin
      bank_b[b_addr] <= b_wd;
      own_b[b_addr]  <= ~own_a[b_addr];
    end
  end

  logic a_sees_a, b_sees_a;
  assign a_sees_a = (own_a[a_addr] == own_b[a_addr]);
  assign b_sees_a = (own_a[b_addr] == own_b[b_addr]);
  assign a_rd = a_sees_a ? bank_a[a_addr] : bank_b[a_addr];
  assign b_rd = b_sees_a ? bank_a[b_addr] : bank_b[b_addr];

  // R3
  own_write_visible_chk: assert property (@(posedge a_clk)
    a_we |=> (a_addr != $past(a_addr) || a_rd == $past(a_wd)));
endmodule

// File: rtl/dpram_read_stage.sv
`timescale 1ns/1ps
module dpram_read_stage
  import dpram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe,
  input  logic              rd_q,
  input  logic              outen_q,
  input  logic [LANES-1:0]  lane_q,
  input  logic [WORD_W-1:0] arr_q,
  output logic [WORD_W-1:0] rdata
);
  logic              show_ev;
  logic [WORD_W-1:0] flow_w;
  logic [WORD_W-1:0] stage_q;

  assign show_ev = rd_q && outen_q;
  assign flow_w  = lane_gate(arr_q, lane_q) & {WORD_W{show_ev}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= flow_w;
  end

  assign rdata = pipe ? stage_q : flow_w;

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !(rd_q && outen_q)) |-> (rdata == '0));
  // R4
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !lane_q[0]) |-> (rdata[LANE_W-1:0] == '0));
  // R8
  pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && outen_q && pipe) |=>
      (!pipe || rdata == lane_gate($past(arr_q), $past(lane_q))));
endmodule

// File: rtl/dpram_burst2.sv
`timescale 1ns/1ps
module dpram_burst2
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              l_clk,
  input  logic              l_rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [WORD_W-1:0] l_wdata,
  input  logic              l_rw_n,
  input  logic              l_cs0_n,
  input  logic              l_cs1,
  input  logic [LANES-1:0]  l_lane_n,
  input  logic              l_outen_n,
  input  logic              l_load_n,
  input  logic              l_adv_n,
  input  logic              l_clr_n,
  input  logic              l_pipe,
  output logic [WORD_W-1:0] l_rdata,
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [WORD_W-1:0] r_wdata,
  input  logic              r_rw_n,
  input  logic              r_cs0_n,
  input  logic              r_cs1,
  input  logic [LANES-1:0]  r_lane_n,
  input  logic              r_outen_n,
  input  logic              r_load_n,
  input  logic              r_adv_n,
  input  logic              r_clr_n,
  input  logic              r_pipe,
  output logic [WORD_W-1:0] r_rdata
);
  logic [ADDR_W-1:0] l_a, r_a;
  logic [WORD_W-1:0] l_wd, r_wd, l_arr, r_arr;
  logic              l_wr, r_wr, l_rd, r_rd, l_oe, r_oe;
  logic [LANES-1:0]  l_ln, r_ln;

  dpram_port_front #(.ADDR_W(ADDR_W)) u_front_l (
    .clk(l_clk), .rst_n(l_rst_n), .addr_in(l_addr), .wdata_in(l_wdata),
    .rw_n(l_rw_n), .cs0_n(l_cs0_n), .cs1(l_cs1), .lane_n(l_lane_n),
    .outen_n(l_outen_n), .load_n(l_load_n), .adv_n(l_adv_n), .clr_n(l_clr_n),
    .addr_q(l_a), .wdata_q(l_wd), .wr_q(l_wr), .rd_q(l_rd), .outen_q(l_oe),
    .lane_q(l_ln));

  dpram_port_front #(.ADDR_W(ADDR_W)) u_front_r (
    .clk(r_clk), .rst_n(r_rst_n), .addr_in(r_addr), .wdata_in(r_wdata),
    .rw_n(r_rw_n), .cs0_n(r_cs0_n), .cs1(r_cs1), .lane_n(r_lane_n),
    .outen_n(r_outen_n), .load_n(r_load_n), .adv_n(r_adv_n), .clr_n(r_clr_n),
    .addr_q(r_a), .wdata_q(r_wd), .wr_q(r_wr), .rd_q(r_rd), .outen_q(r_oe),
    .lane_q(r_ln));

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    dpram_lane_store #(.ADDR_W(ADDR_W), .W(LANE_W)) u_store (
      .a_clk (l_clk),
      .a_we  (l_wr && l_ln[gi]),
      .a_addr(l_a),
      .a_wd  (l_wd[gi*LANE_W +: LANE_W]),
      .a_rd  (l_arr[gi*LANE_W +: LANE_W]),
      .b_clk (r_clk),
      .b_we  (r_wr && r_ln[gi]),
      .b_addr(r_a),
      .b_wd  (r_wd[gi*LANE_W +: LANE_W]),
      .b_rd  (r_arr[gi*LANE_W +: LANE_W]));
  end

  dpram_read_stage u_out_l (
    .clk(l_clk), .rst_n(l_rst_n), .pipe(l_pipe), .rd_q(l_rd), .outen_q(l_oe),
    .lane_q(l_ln), .arr_q(l_arr), .rdata(l_rdata));

  dpram_read_stage u_out_r (
    .clk(r_clk), .rst_n(r_rst_n), .pipe(r_pipe), .rd_q(r_rd), .outen_q(r_oe),
    .lane_q(r_ln), .arr_q(r_arr), .rdata(r_rdata));
endmodule

// File: tb/dpram_burst2_test.sv
`timescale 1ns/1ps
module dpram_burst2_test;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int LAST  = DEPTH - 1;

  logic l_clk = 1'b0, r_clk = 1'b0;
  always #2   l_clk = ~l_clk;   // 250 MHz
  always #3.5 r_clk = ~r_clk;   // unrelated slower clock

  logic          l_rst_n = 1'b0, r_rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [17:0]   l_wdata = '0, r_wdata = '0;
  logic          l_rw_n = 1'b1, r_rw_n = 1'b1;
  logic          l_cs0_n = 1'b1, r_cs0_n = 1'b1;
  logic          l_cs1 = 1'b0, r_cs1 = 1'b0;
  logic [1:0]    l_lane_n = 2'b11, r_lane_n = 2'b11;
  logic          l_outen_n = 1'b1, r_outen_n = 1'b1;
  logic          l_load_n = 1'b1, r_load_n = 1'b1;
  logic          l_adv_n = 1'b1, r_adv_n = 1'b1;
  logic          l_clr_n = 1'b1, r_clr_n = 1'b1;
  logic          l_pipe = 1'b0, r_pipe = 1'b0;
  logic [17:0]   l_rdata, r_rdata;

  dpram_burst2 #(.ADDR_W(AW)) uut (
    .l_clk(l_clk), .l_rst_n(l_rst_n), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rw_n(l_rw_n), .l_cs0_n(l_cs0_n), .l_cs1(l_cs1), .l_lane_n(l_lane_n),
    .l_outen_n(l_outen_n), .l_load_n(l_load_n), .l_adv_n(l_adv_n),
    .l_clr_n(l_clr_n), .l_pipe(l_pipe), .l_rdata(l_rdata),
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rw_n(r_rw_n), .r_cs0_n(r_cs0_n), .r_cs1(r_cs1), .r_lane_n(r_lane_n),
    .r_outen_n(r_outen_n), .r_load_n(r_load_n), .r_adv_n(r_adv_n),
    .r_clr_n(r_clr_n), .r_pipe(r_pipe), .r_rdata(r_rdata));

  typedef struct {
    int          due;
    logic [17:0] exp;
    logic [17:0] alt;
    string       tag;
  } item_t;

  item_t lq[$];
  item_t rq[$];
  int lcyc = 0, rcyc = 0;
  int checks = 0, errors = 0;
  logic [17:0] ref_mem [DEPTH];
  int cnt [2];

  always @(posedge l_clk) lcyc <= lcyc + 1;
  always @(posedge r_clk) rcyc <= rcyc + 1;

  task automatic check(input string tag, input logic [17:0] got,
                       input logic [17:0] exp, input logic [17:0] alt);
    checks++;
    if (got !== exp && got !== alt) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (or %h)", tag, got, exp, alt);
    end
  endtask

  // Monitors: compare each output sample against queued expectations
  always @(negedge l_clk) begin
    while (lq.size() > 0 && lq[0].due <= lcyc) begin
      item_t it;
      it = lq.pop_front();
      check(it.tag, l_rdata, it.exp, it.alt);
    end
  end

  always @(negedge r_clk) begin
    while (rq.size() > 0 && rq[0].due <= rcyc) begin
      item_t it;
      it = rq.pop_front();
      check(it.tag, r_rdata, it.exp, it.alt);
    end
  end

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 7919) ^ 32'h2C3A5);
  endfunction

  // Driver: one captured cycle on side p (0 left, 1 right), with its model.
  task automatic drive(input int p, input bit wr, input bit cs0n, input bit cs1,
                       input logic [1:0] ln, input bit oen, input bit ld,
                       input bit adv, input bit clr, input int a,
                       input logic [17:0] d, input string tag,
                       input bit two = 1'b0, input logic [17:0] va = '0,
                       input logic [17:0] vb = '0);
    int k;
    bit en;
    logic [17:0] m;
    item_t it;
    if (p == 0) begin
      @(negedge l_clk);
      l_addr = a[AW-1:0]; l_wdata = d; l_rw_n = !wr; l_cs0_n = cs0n;
      l_cs1 = cs1; l_lane_n = ln; l_outen_n = oen; l_load_n = !ld;
      l_adv_n = !adv; l_clr_n = !clr;
      k = lcyc + 1 + int'(l_pipe);
    end else begin
      @(negedge r_clk);
      r_addr = a[AW-1:0]; r_wdata = d; r_rw_n = !wr; r_cs0_n = cs0n;
      r_cs1 = cs1; r_lane_n = ln; r_outen_n = oen; r_load_n = !ld;
      r_adv_n = !adv; r_clr_n = !clr;
      k = rcyc + 1 + int'(r_pipe);
    end
    if (clr)      cnt[p] = 0;
    else if (ld)  cnt[p] = a;
    else if (adv) cnt[p] = (cnt[p] + 1) % DEPTH;
    en = !cs0n && cs1;
    m  = {{9{!ln[1]}}, {9{!ln[0]}}};
    if (en && wr) ref_mem[cnt[p]] = (ref_mem[cnt[p]] & ~m) | (d & m);
    it.due = k;
    it.tag = tag;
    if (en && !wr && !oen) begin
      it.exp = (two ? va : ref_mem[cnt[p]]) & m;
      it.alt = two ? (vb & m) : it.exp;
    end else begin
      it.exp = '0;
      it.alt = '0;
    end
    if (p == 0) lq.push_back(it); else rq.push_back(it);
    // R1: disturb address and data right after the capture edge
    if (p == 0) begin
      @(posedge l_clk); #1; l_addr = ~l_addr; l_wdata = ~l_wdata;
    end else begin
      @(posedge r_clk); #1; r_addr = ~r_addr; r_wdata = ~r_wdata;
    end
  endtask

  task automatic wr_ld(input int p, input int a, input logic [17:0] d,
                       input logic [1:0] ln, input string tag);
    drive(p, 1, 0, 1, ln, 1, 1, 0, 0, a, d, tag);
  endtask
  task automatic wr_adv(input int p, input logic [17:0] d, input string tag);
    drive(p, 1, 0, 1, 2'b00, 1, 0, 1, 0, 0, d, tag);
  endtask
  task automatic rd_ld(input int p, input int a, input logic [1:0] ln, input string tag);
    drive(p, 0, 0, 1, ln, 0, 1, 0, 0, a, '0, tag);
  endtask
  task automatic rd_adv(input int p, input string tag);
    drive(p, 0, 0, 1, 2'b00, 0, 0, 1, 0, 0, '0, tag);
  endtask
  task automatic idle(input int p, input int n);
    for (int i = 0; i < n; i++) drive(p, 0, 1, 0, 2'b00, 0, 0, 0, 0, 0, '0, "R4 idle");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cnt[0] = 0;
    cnt[1] = 0;
    repeat (3) @(negedge r_clk);
    check("R11 reset left rdata", l_rdata, '0, '0);
    check("R11 reset right rdata", r_rdata, '0, '0);
    @(negedge l_clk); l_rst_n = 1'b1;
    @(negedge r_clk); r_rst_n = 1'b1;

    // Left, flow-through: burst write then burst read
    wr_ld(0, 10, pat(0), 2'b00, "R4 write shows zero");
    for (int i = 1; i < 8; i++) wr_adv(0, pat(i), "R5 advance write");
    rd_ld(0, 10, 2'b00, "R7 R1 flow read");
    for (int i = 1; i < 8; i++) rd_adv(0, "R5 R7 burst read");

    // Lane masking
    wr_ld(0, 10, 18'h3FFFF, 2'b10, "R3 lower lane write");
    wr_ld(0, 11, 18'h00000, 2'b01, "R3 upper lane write");
    rd_ld(0, 10, 2'b00, "R3 lower lane only changed");
    rd_ld(0, 11, 2'b00, "R3 upper lane only changed");
    rd_ld(0, 12, 2'b01, "R4 disabled lane reads zero");

    // Chip selects
    drive(0, 1, 0, 0, 2'b00, 1, 1, 0, 0, 13, 18'h0, "R2 cs1 low");
    drive(0, 1, 1, 1, 2'b00, 1, 1, 0, 0, 14, 18'h0, "R2 cs0_n high");
    rd_ld(0, 13, 2'b00, "R2 word 13 unchanged");
    rd_ld(0, 14, 2'b00, "R2 word 14 unchanged");
    drive(0, 0, 0, 1, 2'b00, 1, 1, 0, 0, 15, '0, "R4 output disabled");

    // Counter wrap and priority
    wr_ld(0, LAST, pat(40), 2'b00, "R6 write last");
    wr_adv(0, pat(41), "R6 write after wrap");
    rd_ld(0, LAST, 2'b00, "R6 read last");
    rd_adv(0, "R6 read wrapped to zero");
    drive(0, 0, 0, 1, 2'b00, 0, 1, 0, 1, 5, '0, "R5 clear beats load");
    drive(0, 0, 0, 1, 2'b00, 0, 1, 1, 0, 16, '0, "R5 load beats advance");
    drive(0, 0, 0, 1, 2'b00, 0, 0, 0, 0, 0, '0, "R5 hold");
    drive(0, 0, 0, 1, 2'b00, 0, 0, 1, 1, 0, '0, "R5 clear beats advance");
    idle(0, 3);

    // Left, pipelined
    l_pipe = 1'b1;
    rd_ld(0, 10, 2'b00, "R8 pipelined read");
    for (int i = 1; i < 8; i++) rd_adv(0, "R8 pipelined burst");
    rd_ld(0, 12, 2'b10, "R8 R4 pipelined lane gate");
    idle(0, 3);

    // Right side reads left data, then writes for the left side
    rd_ld(1, 10, 2'b00, "R9 right flow read");
    for (int i = 1; i < 8; i++) rd_adv(1, "R9 right burst read");
    wr_ld(1, 100, pat(50), 2'b00, "R9 right write");
    for (int i = 1; i < 4; i++) wr_adv(1, pat(50 + i), "R9 right write");
    wr_ld(1, 12, 18'h1FE00, 2'b01, "R9 right upper lane write");
    idle(1, 2);
    r_pipe = 1'b1;
    rd_ld(1, 100, 2'b00, "R8 right pipelined read");
    rd_adv(1, "R8 right pipelined read");
    idle(1, 3);
    rd_ld(0, 100, 2'b00, "R9 left reads right data");
    for (int i = 1; i < 4; i++) rd_adv(0, "R9 left reads right data");
    rd_ld(0, 12, 2'b00, "R9 mixed lane owners");
    idle(0, 3);

    // Collision: left writes while right reads the same word
    wr_ld(0, 20, pat(60), 2'b00, "R10 setup");
    idle(0, 3);
    fork
      wr_ld(0, 20, pat(61), 2'b00, "R10 write");
      for (int i = 0; i < 4; i++)
        drive(1, 0, 0, 1, 2'b00, 0, 1, 0, 0, 20, '0, "R10 old or new", 1'b1, pat(60), pat(61));
    join
    idle(0, 3);
    idle(1, 3);
    rd_ld(1, 20, 2'b00, "R10 settled new value");
    idle(1, 3);

    // Mid-run left reset
    idle(0, 3);
    @(negedge l_clk); l_rst_n = 1'b0;
    #1 check("R11 rdata cleared by reset", l_rdata, '0, '0);
    @(negedge l_clk); l_rst_n = 1'b1;
    cnt[0] = 0;
    drive(0, 0, 0, 1, 2'b00, 0, 0, 0, 0, 0, '0, "R11 counter at zero, storage kept");
    idle(0, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule